// File: doc/BRIEF.md
# Deferred Fault Tracker for Hoisted Loads

This block holds one poison flag for each architectural register so that loads moved above their guarding branch can run without trapping. A speculative load that faults sets the flag of its destination register and nothing else happens at that moment. A later check operation names the register and carries the guarding predicate. A precise exception is raised only when that predicate is true and the flag is set. Loads that are not speculative keep their normal behaviour, and a fault on one of them traps at once.

Each cycle the block takes at most one completed load, one ordinary register write and one check. Exceptions leave through a registered output. The output is valid for one cycle and carries the register index and a bit that tells a deferred fault from an immediate load fault. No reorder buffer is involved. All the deferred state is the flag vector, which reset clears.

Top module: `spl_tracker`

## Requirements
- R1: After reset every poison flag is clear, so a check with a true predicate on any register raises nothing, and `exc_valid` is 0 while reset is held.
- R2: A completed load with `ld_spec`=1 and `ld_fault`=1 raises no exception and sets the poison flag of `ld_reg`.
- R3: A completed load with `ld_spec`=0 and `ld_fault`=1 raises an exception in the cycle after it is presented, with `exc_deferred`=0 and `exc_reg` equal to `ld_reg`. It leaves that register's poison flag unchanged.
- R4: A check with `chk_pred`=1 on a register whose flag is set raises an exception in the following cycle, with `exc_deferred`=1 and `exc_reg` equal to `chk_reg`.
- R5: A check with `chk_pred`=0, or on a register whose flag is clear, raises nothing. No check changes any poison flag.
- R6: A completed load with `ld_fault`=0, speculative or not, clears the flag of `ld_reg`. An ordinary write (`wr_valid`=1) clears the flag of `wr_reg`.
- R7: When a speculative faulting load and an ordinary write name the same register in the same cycle, the flag ends set, because the load takes precedence.
- R8: A check reads the flag as it stood before any load or write presented in the same cycle.
- R9: `exc_valid` is a one-cycle pulse per event. It is 0 in the cycle after an exception unless a new trapping or raising event was presented in the cycle before.
- R10: If an immediate load fault and a raising check arrive in the same cycle, only the load fault is reported (`exc_deferred`=0, `exc_reg`=`ld_reg`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load completes this cycle |
| ld_reg | input | IDX_W | Destination register of the load |
| ld_fault | input | 1 | The load would fault |
| ld_spec | input | 1 | The load is control-speculative |
| wr_valid | input | 1 | Ordinary register write this cycle |
| wr_reg | input | IDX_W | Register written |
| chk_valid | input | 1 | Check operation issued this cycle |
| chk_reg | input | IDX_W | Register the check examines |
| chk_pred | input | 1 | Guarding predicate of the check |
| exc_valid | output | 1 | Exception pulse |
| exc_reg | output | IDX_W | Register named by the exception |
| exc_deferred | output | 1 | 1 for a deferred (check) exception, 0 for an immediate load fault |

## Verification
The hardest cases to reach are the ones where the ports collide in a single cycle. Examples are a check that reads a flag while a load or write to the same register updates it, a speculative fault racing an ordinary write, and an immediate load fault racing a raising check. Random stimulus is drawn over a small register window, so that indices collide often. Directed sequences set up each collision explicitly. A bench model tracks every flag and predicts each cycle's exception from the flag values that were in place before the cycle.

// File: rtl/spl_pkg.sv
package spl_pkg;
  // Kind of exception reported on the output
  typedef enum logic {
    EXC_LOAD  = 1'b0,
    EXC_DEFER = 1'b1
  } exc_kind_e;

  // Effect of one completed load on the poison state
  typedef struct packed {
    logic set;    // speculative fault: mark register
    logic clr;    // clean result: unmark register
    logic trap;   // non-speculative fault: report now
  } ld_effect_t;
endpackage

// File: rtl/spl_load_decode.sv
module spl_load_decode
  import spl_pkg::*;
(
  input  logic       ld_valid,
  input  logic       ld_fault,
  input  logic       ld_spec,
  output ld_effect_t effect
);
  always_comb begin
    effect.set  = ld_valid &  ld_fault &  ld_spec;
    effect.clr  = ld_valid & ~ld_fault;
    effect.trap = ld_valid &  ld_fault & ~ld_spec;
  end
endmodule

// File: rtl/spl_poison_file.sv
module spl_poison_file #(
  parameter int NREGS = 32,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_a_en,
  input  logic [IDX_W-1:0] clr_a_idx,
  input  logic             clr_b_en,
  input  logic [IDX_W-1:0] clr_b_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  logic [NREGS-1:0] poison_q;

  // One flag per register; set has priority over either clear
  for (genvar i = 0; i < NREGS; i++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = set_en   && (set_idx   == IDX_W'(i));
    assign hit_clr = (clr_a_en && (clr_a_idx == IDX_W'(i))) ||
                     (clr_b_en && (clr_b_idx == IDX_W'(i)));
    always_ff @(posedge clk) begin
      if (rst)          poison_q[i] <= 1'b0;
      else if (hit_set) poison_q[i] <= 1'b1;
      else if (hit_clr) poison_q[i] <= 1'b0;
    end
  end

  // Read returns the value held before this cycle's updates
  assign rd_bit = (int'(rd_idx) < NREGS) ? poison_q[rd_idx] : 1'b0;

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    set_en |=> poison_q[$past(set_idx)]);

  p_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_b_en && !(set_en && set_idx == clr_b_idx)) |=> !poison_q[$past(clr_b_idx)]);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_a_en && !clr_b_en) |=> $stable(poison_q));
endmodule

// File: rtl/spl_check_eval.sv
module spl_check_eval (
  input  logic chk_valid,
  input  logic chk_pred,
  input  logic poison_bit,
  output logic raise
);
  // Only a taken path with a marked register produces a fault
  assign raise = chk_valid & chk_pred & poison_bit;
endmodule

// File: rtl/spl_tracker.sv
module spl_tracker
  import spl_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_reg,
  input  logic             ld_fault,
  input  logic             ld_spec,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_reg,
  input  logic             chk_valid,
  input  logic [IDX_W-1:0] chk_reg,
  input  logic             chk_pred,
  output logic             exc_valid,
  output logic [IDX_W-1:0] exc_reg,
  output logic             exc_deferred
);
  ld_effect_t ld_eff;
  logic       poison_rd;
  logic       chk_raise;

  spl_load_decode u_dec (
    .ld_valid (ld_valid),
    .ld_fault (ld_fault),
    .ld_spec  (ld_spec),
    .effect   (ld_eff)
  );

  spl_poison_file #(.NREGS(NREGS)) u_file (
    .clk       (clk),
    .rst       (rst),
    .set_en    (ld_eff.set),
    .set_idx   (ld_reg),
    .clr_a_en  (ld_eff.clr),
    .clr_a_idx (ld_reg),
    .clr_b_en  (wr_valid),
    .clr_b_idx (wr_reg),
    .rd_idx    (chk_reg),
    .rd_bit    (poison_rd)
  );

  spl_check_eval u_chk (
    .chk_valid  (chk_valid),
    .chk_pred   (chk_pred),
    .poison_bit (poison_rd),
    .raise      (chk_raise)
  );

  // Registered exception output; an immediate load fault wins
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid    <= 1'b0;
      exc_reg      <= '0;
      exc_deferred <= 1'b0;
    end else begin
      exc_valid <= ld_eff.trap | chk_raise;
      if (ld_eff.trap) begin
        exc_reg      <= ld_reg;
        exc_deferred <= EXC_LOAD;
      end else if (chk_raise) begin
        exc_reg      <= chk_reg;
        exc_deferred <= EXC_DEFER;
      end
    end
  end

  p_trap_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_fault && !ld_spec) |=>
      (exc_valid && !exc_deferred && exc_reg == $past(ld_reg)));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!(ld_valid && ld_fault && !ld_spec) && !(chk_valid && chk_pred)) |=> !exc_valid);

  p_defer_src_r4: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_deferred) |-> $past(chk_valid && chk_pred));
endmodule

// File: tb/tb_spl_tracker.sv
`timescale 1ns/1ps
module tb_spl_tracker;
  localparam int NREGS = 32;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst;
  logic ld_valid, ld_fault, ld_spec, wr_valid, chk_valid, chk_pred;
  logic [IDX_W-1:0] ld_reg, wr_reg, chk_reg;
  logic exc_valid, exc_deferred;
  logic [IDX_W-1:0] exc_reg;

  always #2.5 clk = ~clk;

  spl_tracker #(.NREGS(NREGS)) dut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_fault(ld_fault), .ld_spec(ld_spec),
    .wr_valid(wr_valid), .wr_reg(wr_reg),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_pred(chk_pred),
    .exc_valid(exc_valid), .exc_reg(exc_reg), .exc_deferred(exc_deferred)
  );

  int checks = 0;
  int fails  = 0;
  logic [NREGS-1:0] model;

  task automatic report(input string tag, input logic ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, predict, update model, compare next falling edge
  task automatic step(input logic lv, input logic [IDX_W-1:0] lr, input logic lf, input logic ls,
                      input logic wv, input logic [IDX_W-1:0] wr,
                      input logic cv, input logic [IDX_W-1:0] cr, input logic cp,
                      input string tag);
    logic trap, raise, ev, ed;
    logic [IDX_W-1:0] er;
    string t;
    ld_valid = lv; ld_reg = lr; ld_fault = lf; ld_spec = ls;
    wr_valid = wv; wr_reg = wr;
    chk_valid = cv; chk_reg = cr; chk_pred = cp;
    trap  = lv && lf && !ls;
    raise = cv && cp && model[cr];
    ev = trap || raise;
    er = trap ? lr : cr;
    ed = !trap;
    if (wv) model[wr] = 1'b0;
    if (lv && !trap) model[lr] = lf && ls;
    t = tag;
    if (t == "") t = trap ? "R3" : (raise ? "R4" : "R5");
    @(negedge clk);
    if (ev)
      report(t, exc_valid === 1'b1 && exc_reg === er && exc_deferred === ed,
             $sformatf("v=%b r=%0d d=%b", exc_valid, exc_reg, exc_deferred),
             $sformatf("v=1 r=%0d d=%b", er, ed));
    else
      report(t, exc_valid === 1'b0,
             $sformatf("v=%b", exc_valid), "v=0");
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model = '0;
    rst = 1'b1;
    ld_valid = 0; ld_reg = 0; ld_fault = 0; ld_spec = 0;
    wr_valid = 0; wr_reg = 0; chk_valid = 0; chk_reg = 0; chk_pred = 0;
    repeat (3) @(negedge clk);
    report("R1", exc_valid === 1'b0, $sformatf("v=%b", exc_valid), "v=0");
    rst = 1'b0;

    // R1: no flag set after reset
    for (int i = 0; i < NREGS; i++) step(0, 0, 0, 0, 0, 0, 1, IDX_W'(i), 1, "R1");

    // R2: speculative fault marks silently, later check raises (R4)
    step(1, 5, 1, 1, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 1, 5, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 1, 5, 1, "R4");
    idle("R9");
    step(0, 0, 0, 0, 0, 0, 1, 5, 1, "R4");

    // R3: immediate trap, flag untouched
    step(1, 7, 1, 0, 0, 0, 0, 0, 0, "R3");
    idle("R9");
    step(0, 0, 0, 0, 0, 0, 1, 7, 1, "R3");

    // R6: clean loads and writes clear
    step(1, 9, 1, 1, 0, 0, 0, 0, 0, "R2");
    step(1, 9, 0, 1, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 9, 1, "R6");
    step(1, 9, 1, 1, 0, 0, 0, 0, 0, "R2");
    step(1, 9, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 9, 1, "R6");
    step(0, 0, 0, 0, 1, 5, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 5, 1, "R6");

    // R7: speculative fault beats same-cycle write
    step(1, 12, 1, 1, 1, 12, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 12, 1, "R7");

    // R8: check sees old value while same register is updated
    step(1, 3, 1, 1, 0, 0, 1, 3, 1, "R8");
    step(0, 0, 0, 0, 1, 3, 1, 3, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 3, 1, "R8");

    // R10: trap and raising check together
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 20, 1, 1, 0, 0, 0, 0, 0, "R2");
    step(1, 21, 1, 0, 0, 0, 1, 20, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 1, 20, 1, "R4");

    // Random traffic over a narrow register window
    for (int n = 0; n < 3000; n++) begin
      logic [IDX_W-1:0] a, b, c;
      a = IDX_W'($urandom_range(0, 5));
      b = IDX_W'($urandom_range(0, 5));
      c = IDX_W'($urandom_range(0, 5));
      step($urandom_range(0, 1), a, $urandom_range(0, 2) == 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 2) == 0, b,
           $urandom_range(0, 1), c, $urandom_range(0, 3) != 0, "");
    end
    idle("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule